// File: doc/BRIEF.md
# Quadrature Early/Late Phase Detector

This block is the digital phase detector in a clock-and-data recovery loop. On every fast-clock cycle it receives three samples of the serial stream. The centre sample is taken on the rising edge of the in-phase clock. The edge sample is taken on its falling edge, where data transitions sit once the loop is locked. The third sample is taken by a quadrature clock. For each cycle the block forwards the centre sample as retimed data. It also compares the previous bit, the edge sample and the current bit to decide whether the data leads or lags the clock. The decision goes out as a one-cycle steering pulse for the charge pump.

When the quadrature sample disagrees with the centre sample, the input jitter is above a quarter of a unit interval. In that case a second, stronger pulse is raised in the same direction as the normal decision, so the loop can make a larger correction. The lock detector drives an enable input. While the enable is low, no correction pulse leaves the block, but retimed data and bit history continue as normal.

Top module: `qpd_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, every output is low in the following cycle.
- R2: `rt_data_o` equals the `data_i` value sampled at the previous clock edge, whatever the value of `en_i`.
- R3: When the current bit differs from the previous bit and `edge_i` equals the current bit, `lead_o` is high for the one cycle after that edge, and `lag_o` is low.
- R4: When the current bit differs from the previous bit and `edge_i` equals the previous bit, `lag_o` is high for the one cycle after that edge, and `lead_o` is low.
- R5: When the current bit equals the previous bit, none of the four correction outputs is raised, whatever `edge_i` and `quad_i` are.
- R6: On a cycle where R3 or R4 yields a pulse and `quad_i` differs from `data_i`, the matching large output (`lead_big_o` with `lead_o`, `lag_big_o` with `lag_o`) is raised in the same cycle as that pulse.
- R7: When `quad_i` equals `data_i`, neither large output is raised.
- R8: While `en_i` is low at an edge, all four correction outputs are low in the following cycle. The bit history is still updated, so the first bit after the enable is raised again is judged against the last bit seen while the enable was low.
- R9: The first bit after reset produces no correction pulse, because it has no previous bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock, one bit per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Phase loop selected by the lock detector |
| data_i | input | 1 | Centre sample (in-phase rising edge) |
| edge_i | input | 1 | Transition sample (in-phase falling edge) |
| quad_i | input | 1 | Quadrature-clock sample |
| rt_data_o | output | 1 | Retimed data |
| lead_o | output | 1 | Data-leads pulse |
| lag_o | output | 1 | Data-lags pulse |
| lead_big_o | output | 1 | Large correction, lead direction |
| lag_big_o | output | 1 | Large correction, lag direction |

## Verification
The hardest situation to reach is the point where the enable returns after a gap. There the bit history must carry a value that was captured while pulses were suppressed. The directed stimulus sends a transition while the enable is low and checks that nothing comes out. It then holds the bit at that new value and raises the enable, and a pulse at that point would show that the history was frozen. It next sends a real transition and checks that the pulse direction matches the suppressed bit. Large-correction cases are driven with the quadrature sample set both equal to and opposite from the centre sample. This is done on lead transitions, on lag transitions and on flat data, so that the large outputs are shown to follow the direction and never fire on their own.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    typedef enum logic [1:0] {
        PD_HOLD = 2'd0,
        PD_LEAD = 2'd1,
        PD_LAG  = 2'd2
    } pd_dir_e;

    typedef struct packed {
        logic data;
        logic edg;
        logic quad;
    } pd_samp_s;

    typedef struct packed {
        pd_dir_e dir;
        logic    boost;
    } pd_vote_s;

    // Early/late rule on previous bit, edge sample and current bit.
    function automatic pd_dir_e classify(input logic prev, input logic edg, input logic cur);
        pd_dir_e d;
        if (prev == cur)      d = PD_HOLD;
        else if (edg == cur)  d = PD_LEAD;
        else                  d = PD_LAG;
        return d;
    endfunction

endpackage

// File: rtl/qpd_history.sv
module qpd_history (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic prev_o,
    output logic primed_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_o   <= 1'b0;
            primed_o <= 1'b0;
        end else begin
            prev_o   <= bit_i;
            primed_o <= 1'b1;
        end
    end
endmodule

// File: rtl/qpd_vote.sv
module qpd_vote
    import qpd_pkg::*;
(
    input  logic     prev_i,
    input  logic     primed_i,
    input  pd_samp_s samp_i,
    output pd_vote_s vote_o
);
    pd_dir_e raw_dir;

    always_comb begin
        raw_dir      = classify(prev_i, samp_i.edg, samp_i.data);
        vote_o.dir   = primed_i ? raw_dir : PD_HOLD;
        vote_o.boost = (vote_o.dir != PD_HOLD) && (samp_i.quad != samp_i.data);
    end
endmodule

// File: rtl/qpd_drive.sv
module qpd_drive
    import qpd_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     en_i,
    input  pd_vote_s vote_i,
    output logic     lead_o,
    output logic     lag_o,
    output logic     lead_big_o,
    output logic     lag_big_o
);
    logic act_lead, act_lag;

    always_comb begin
        act_lead = en_i && (vote_i.dir == PD_LEAD);
        act_lag  = en_i && (vote_i.dir == PD_LAG);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lead_o     <= 1'b0;
            lag_o      <= 1'b0;
            lead_big_o <= 1'b0;
            lag_big_o  <= 1'b0;
        end else begin
            lead_o     <= act_lead;
            lag_o      <= act_lag;
            lead_big_o <= act_lead && vote_i.boost;
            lag_big_o  <= act_lag && vote_i.boost;
        end
    end

    // R3
    dir_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(lead_o && lag_o));

    // R6
    big_lead_dir_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lead_big_o |-> lead_o);

    // R6
    big_lag_dir_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lag_big_o |-> lag_o);

    // R8
    gated_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !(lead_o || lag_o || lead_big_o || lag_big_o));

endmodule

// File: rtl/qpd_top.sv
module qpd_top
    import qpd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic data_i,
    input  logic edge_i,
    input  logic quad_i,
    output logic rt_data_o,
    output logic lead_o,
    output logic lag_o,
    output logic lead_big_o,
    output logic lag_big_o
);
    pd_samp_s samp;
    pd_vote_s vote;
    logic     prev_bit;
    logic     primed;

    assign samp = '{data: data_i, edg: edge_i, quad: quad_i};

    qpd_history u_hist (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bit_i    (data_i),
        .prev_o   (prev_bit),
        .primed_o (primed)
    );

    assign rt_data_o = prev_bit;

    qpd_vote u_vote (
        .prev_i   (prev_bit),
        .primed_i (primed),
        .samp_i   (samp),
        .vote_o   (vote)
    );

    qpd_drive u_drive (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .vote_i     (vote),
        .lead_o     (lead_o),
        .lag_o      (lag_o),
        .lead_big_o (lead_big_o),
        .lag_big_o  (lag_big_o)
    );

    // R2
    retime_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (rt_data_o == $past(data_i)));

    // R5
    flat_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (data_i == rt_data_o) |=> !(lead_o || lag_o || lead_big_o || lag_big_o));

    // R7
    quad_agree_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (quad_i == data_i) |=> !(lead_big_o || lag_big_o));

endmodule

// File: tb/qpd_top_tb.sv
module qpd_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic d = 1'b0, e = 1'b0, q = 1'b0;
    logic rt, ld, lg, ldb, lgb;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic prev_m   = 1'b0;
    logic primed_m = 1'b0;

    always #5 clk = ~clk;

    qpd_top u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .data_i(d), .edge_i(e), .quad_i(q),
        .rt_data_o(rt), .lead_o(ld), .lag_o(lg),
        .lead_big_o(ldb), .lag_big_o(lgb)
    );

    task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    task automatic step(input logic nd, input logic ne, input logic nq, input logic nen,
                        input string tag);
        logic xl, xg, xb;
        xl = nen && primed_m && (prev_m != nd) && (ne == nd);
        xg = nen && primed_m && (prev_m != nd) && (ne == prev_m);
        xb = (nq != nd);
        d = nd; e = ne; q = nq; en = nen;
        @(posedge clk); #2;
        cmp(tag, "rt_data", rt, nd);
        cmp(tag, "lead", ld, xl);
        cmp(tag, "lag", lg, xg);
        cmp(tag, "lead_big", ldb, xl && xb);
        cmp(tag, "lag_big", lgb, xg && xb);
        prev_m = nd;
        primed_m = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; d = 1'b1; e = 1'b1; q = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        cmp("R1", "rt_data", rt, 1'b0);
        cmp("R1", "lead", ld, 1'b0);
        cmp("R1", "lag", lg, 1'b0);
        cmp("R1", "lead_big", ldb, 1'b0);
        cmp("R1", "lag_big", lgb, 1'b0);
        rst = 1'b0; prev_m = 1'b0; primed_m = 1'b0;
    endtask

    task automatic t_first_bit();
        step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
    endtask

    task automatic t_lead();
        step(1'b0, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_lag();
        step(1'b1, 1'b0, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R4");
    endtask

    task automatic t_flat();
        step(1'b0, 1'b1, 1'b1, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_big();
        step(1'b0, 1'b0, 1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_quad_agree();
        step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R7");
    endtask

    task automatic t_disable();
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    initial begin
        t_reset();
        t_first_bit();
        t_lead();
        t_lag();
        t_flat();
        t_big();
        t_quad_agree();
        t_disable();
        t_reset();
        t_first_bit();
        t_lag();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule